// File: doc/BRIEF.md
# Erase-Before-Write Page Manager

This block keeps a small page-organised storage array that follows the erase-before-write rule of flash memory. The array is split into physical erase blocks of `PAGES` pages. Each page is in one of three states: erased, valid or stale. Clients work with logical block numbers. A table maps each logical block to a physical block, and the spare physical blocks form a pool of erased blocks that can be allocated.

Requests arrive on a valid/ready handshake. A request is a read, a write or an erase of one page slot, and data always moves as a whole page. A write to an erased page is stored directly. A write to a page that already holds data is a rewrite, and it cannot happen in place. For a rewrite the block copies every valid page of the old physical block, together with the new page, into an erased spare block. It then switches the logical mapping to the new block in one step and erases the old block in the background.

Each erase keeps the block out of use for `ERASE_CYC` clock cycles and raises `busy_o` for that time. The block keeps a saturating erase counter for each physical block. A block whose counter reaches `WEAR_MAX` is marked worn and is never allocated again.

Top module: `fpm_top`

## Requirements
- R1: After reset, `req_ready_o` is 1, `busy_o` is 0, `resp_valid_o` is 0 and `worn_o` is all zero. Every page is erased, and logical block n maps to physical block n.
- R2: Command encodings are read = 0, write = 1, erase = 2. A read of a valid page responds one cycle after acceptance with `resp_err_o`=0 and the page data. A read of an erased or stale page responds with `resp_err_o`=1 and data 0.
- R3: A write to an erased page stores the data, marks the page valid and responds with `resp_err_o`=0 one cycle after acceptance. It starts no erase.
- R4: A write to a valid page, while an allocatable spare exists, copies every other valid page of the block unchanged into the spare and places the new data in the target slot. It then remaps the logical block to the spare and responds with `resp_err_o`=0.
- R5: The spare chosen is the lowest-numbered physical block that is unmapped, fully erased and not worn. The old block is erased after the remap and joins the spare pool.
- R6: A write to a valid page when no spare is allocatable responds with `resp_err_o`=1, and no page content or mapping changes.
- R7: An erase command erases the physical block mapped to the logical block. `busy_o` rises in the cycle after acceptance and stays high for exactly `ERASE_CYC` cycles, and `req_ready_o` is 0 during that time. The response comes in the cycle after `busy_o` falls. It carries `resp_err_o`=0 and the block's updated erase count in the low bits of `resp_rdata_o`. Afterwards every page of the block reads as erased.
- R8: Each erase increments the erased block's counter, which saturates at `WEAR_MAX` instead of wrapping. The block's bit in `worn_o` is set once the counter equals `WEAR_MAX` and never clears. A worn block is never chosen as a spare.
- R9: Command code 3 is reserved. It responds with `resp_err_o`=1 and changes no state.
- R10: The background erase after a rewrite holds `busy_o` high for exactly `ERASE_CYC` cycles. The rewrite's response is issued in the first of those cycles, and no new request is accepted until the erase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_cmd_i | input | 2 | 0 read, 1 write, 2 erase, 3 reserved |
| req_lblk_i | input | LB_W | Logical block number |
| req_page_i | input | PG_W | Page slot inside the block |
| req_wdata_i | input | DATA_W | Page data for a write |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_err_o | output | 1 | 1 when the request was refused or read no data |
| resp_rdata_o | output | DATA_W | Read data or updated erase count |
| busy_o | output | 1 | High while an erase is in progress |
| worn_o | output | NUM_PBLK | One bit per physical block that has reached the wear limit |

## Verification
The bench builds the block with two logical blocks, three physical blocks (so exactly one spare), 32 pages per block, a 4-cycle erase and a wear limit of 3. It fills and reads back every page slot. It then drives rewrites that alternate between the two logical blocks. The lone spare moves around the array until every block nears the limit and the spare pool runs dry, which brings the refused-rewrite path and the worn flags into reach within a few dozen operations. Repeated erases of one logical block then drive its counter past the limit, which shows the saturation in the returned count.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    PG_ERASED = 2'd0,
    PG_VALID  = 2'd1,
    PG_STALE  = 2'd2
  } pg_state_e;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_ERASE = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COPY  = 2'd1,
    ST_SWAP  = 2'd2,
    ST_ERASE = 2'd3
  } fsm_e;
endpackage

// File: rtl/fpm_page_array.sv
module fpm_page_array
  import fpm_pkg::*;
#(
  parameter int NB = 6,
  parameter int NP = 32,
  parameter int DW = 16,
  parameter int BW = 3,
  parameter int PW = 5,
  localparam int AW = $clog2(NB * NP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] rd_blk_i,
  input  logic [PW-1:0] rd_pg_i,
  output logic [DW-1:0] rd_data_o,
  output pg_state_e     rd_state_o,
  input  logic          wr_en_i,
  input  logic [BW-1:0] wr_blk_i,
  input  logic [PW-1:0] wr_pg_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          stale_en_i,
  input  logic [BW-1:0] stale_blk_i,
  input  logic          erase_en_i,
  input  logic [BW-1:0] erase_blk_i,
  output logic [NB-1:0] clean_o
);
  logic [AW-1:0] wr_idx, rd_idx;
  pg_state_e     st_w  [NB*NP];
  logic [DW-1:0] dat_w [NB*NP];

  assign wr_idx = AW'(wr_blk_i) * AW'(NP) + AW'(wr_pg_i);
  assign rd_idx = AW'(rd_blk_i) * AW'(NP) + AW'(rd_pg_i);

  for (genvar b = 0; b < NB; b++) begin : g_blk
    logic [NP-1:0] erased_v;
    for (genvar p = 0; p < NP; p++) begin : g_pg
      localparam int IX = b * NP + p;
      pg_state_e     s_q;
      logic [DW-1:0] d_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                                  s_q <= PG_ERASED;
        else if (erase_en_i && erase_blk_i == BW'(b))                 s_q <= PG_ERASED;
        else if (stale_en_i && stale_blk_i == BW'(b) && s_q == PG_VALID) s_q <= PG_STALE;
        else if (wr_en_i && wr_idx == AW'(IX))                        s_q <= PG_VALID;
      end

      always_ff @(posedge clk_i) begin
        if (wr_en_i && wr_idx == AW'(IX)) d_q <= wr_data_i;
      end

      assign st_w[IX]    = s_q;
      assign dat_w[IX]   = d_q;
      assign erased_v[p] = (s_q == PG_ERASED);
    end
    assign clean_o[b] = &erased_v;
  end

  assign rd_state_o = st_w[rd_idx];
  assign rd_data_o  = dat_w[rd_idx];
endmodule

// File: rtl/fpm_wear.sv
module fpm_wear #(
  parameter int NB   = 6,
  parameter int WMAX = 100000,
  parameter int BW   = 3,
  localparam int CW  = $clog2(WMAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_en_i,
  input  logic [BW-1:0] inc_blk_i,
  output logic [CW-1:0] cnt_next_o,
  output logic [NB-1:0] worn_o
);
  logic [CW-1:0] cnt_w [NB];

  for (genvar b = 0; b < NB; b++) begin : g_cnt
    logic [CW-1:0] c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) c_q <= '0;
      else if (inc_en_i && inc_blk_i == BW'(b) && c_q != CW'(WMAX)) c_q <= c_q + 1'b1;
    end
    assign cnt_w[b]  = c_q;
    assign worn_o[b] = (c_q == CW'(WMAX));
  end

  // count the selected block will hold after one more erase
  assign cnt_next_o = (cnt_w[inc_blk_i] == CW'(WMAX)) ? CW'(WMAX) : cnt_w[inc_blk_i] + 1'b1;
endmodule

// File: rtl/fpm_alloc.sv
module fpm_alloc #(
  parameter int NB = 6,
  parameter int NL = 4,
  parameter int BW = 3
) (
  input  logic [NL-1:0][BW-1:0] map_i,
  input  logic [NB-1:0]         clean_i,
  input  logic [NB-1:0]         worn_i,
  output logic                  found_o,
  output logic [BW-1:0]         idx_o
);
  logic [NB-1:0] acc [NL+1];
  logic [NB-1:0] avail;

  assign acc[0] = '0;
  for (genvar l = 0; l < NL; l++) begin : g_map
    logic [NB-1:0] hit;
    for (genvar b = 0; b < NB; b++) begin : g_hit
      assign hit[b] = (map_i[l] == BW'(b));
    end
    assign acc[l+1] = acc[l] | hit;
  end

  assign avail   = clean_i & ~acc[NL] & ~worn_i;
  assign found_o = |avail;

  always_comb begin
    idx_o = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (avail[b]) idx_o = BW'(b);
    end
  end
endmodule

// File: rtl/fpm_top.sv
module fpm_top
  import fpm_pkg::*;
#(
  parameter int NUM_LBLK  = 4,
  parameter int NUM_PBLK  = 6,
  parameter int PAGES     = 32,
  parameter int DATA_W    = 16,
  parameter int ERASE_CYC = 50000,
  parameter int WEAR_MAX  = 100000,
  localparam int LB_W = (NUM_LBLK > 1) ? $clog2(NUM_LBLK) : 1,
  localparam int PB_W = (NUM_PBLK > 1) ? $clog2(NUM_PBLK) : 1,
  localparam int PG_W = $clog2(PAGES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [1:0]          req_cmd_i,
  input  logic [LB_W-1:0]     req_lblk_i,
  input  logic [PG_W-1:0]     req_page_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                resp_valid_o,
  output logic                resp_err_o,
  output logic [DATA_W-1:0]   resp_rdata_o,
  output logic                busy_o,
  output logic [NUM_PBLK-1:0] worn_o
);
  localparam int CW   = $clog2(WEAR_MAX + 1);
  localparam int TM_W = $clog2(ERASE_CYC + 1);

  fsm_e                        state_q;
  logic [NUM_LBLK-1:0][PB_W-1:0] map_q;
  logic [LB_W-1:0]             lblk_q;
  logic [PG_W-1:0]             page_q, idx_q;
  logic [DATA_W-1:0]           wdata_q;
  logic [PB_W-1:0]             old_pb_q, new_pb_q, e_blk_q;
  logic                        e_resp_q;
  logic [TM_W-1:0]             tmr_q;
  logic                        resp_valid_q, resp_err_q;
  logic [DATA_W-1:0]           resp_rdata_q;

  logic [PB_W-1:0]   cur_pb, rd_blk, wr_blk;
  logic [PG_W-1:0]   rd_pg, wr_pg;
  logic [DATA_W-1:0] rd_data, wr_data;
  pg_state_e         rd_state;
  logic              wr_en, stale_en, erase_en;
  logic [NUM_PBLK-1:0] clean;
  logic              alloc_found;
  logic [PB_W-1:0]   alloc_idx;
  logic [CW-1:0]     cnt_next;
  logic              accept, in_copy, erase_last, copy_last;

  assign accept     = req_valid_i && (state_q == ST_IDLE);
  assign in_copy    = (state_q == ST_COPY);
  assign erase_last = (state_q == ST_ERASE) && (tmr_q == TM_W'(ERASE_CYC - 1));
  assign copy_last  = (idx_q == PG_W'(PAGES - 1));
  assign cur_pb     = map_q[req_lblk_i];

  // single read port: relocation source while copying, request slot otherwise
  assign rd_blk = in_copy ? old_pb_q : cur_pb;
  assign rd_pg  = in_copy ? idx_q    : req_page_i;

  always_comb begin
    wr_en   = 1'b0;
    wr_blk  = cur_pb;
    wr_pg   = req_page_i;
    wr_data = req_wdata_i;
    if (in_copy) begin
      wr_blk  = new_pb_q;
      wr_pg   = idx_q;
      wr_en   = (idx_q == page_q) || (rd_state == PG_VALID);
      wr_data = (idx_q == page_q) ? wdata_q : rd_data;
    end else if (accept && req_cmd_i == CMD_WRITE && rd_state == PG_ERASED) begin
      wr_en = 1'b1;
    end
  end

  assign stale_en = (state_q == ST_SWAP);
  assign erase_en = erase_last;

  fpm_page_array #(
    .NB(NUM_PBLK), .NP(PAGES), .DW(DATA_W), .BW(PB_W), .PW(PG_W)
  ) u_pages (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_blk_i    (rd_blk),
    .rd_pg_i     (rd_pg),
    .rd_data_o   (rd_data),
    .rd_state_o  (rd_state),
    .wr_en_i     (wr_en),
    .wr_blk_i    (wr_blk),
    .wr_pg_i     (wr_pg),
    .wr_data_i   (wr_data),
    .stale_en_i  (stale_en),
    .stale_blk_i (old_pb_q),
    .erase_en_i  (erase_en),
    .erase_blk_i (e_blk_q),
    .clean_o     (clean)
  );

  fpm_wear #(
    .NB(NUM_PBLK), .WMAX(WEAR_MAX), .BW(PB_W)
  ) u_wear (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_en_i   (erase_en),
    .inc_blk_i  (e_blk_q),
    .cnt_next_o (cnt_next),
    .worn_o     (worn_o)
  );

  fpm_alloc #(
    .NB(NUM_PBLK), .NL(NUM_LBLK), .BW(PB_W)
  ) u_alloc (
    .map_i   (map_q),
    .clean_i (clean),
    .worn_i  (worn_o),
    .found_o (alloc_found),
    .idx_o   (alloc_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      for (int l = 0; l < NUM_LBLK; l++) map_q[l] <= PB_W'(l);
      lblk_q       <= '0;
      page_q       <= '0;
      idx_q        <= '0;
      wdata_q      <= '0;
      old_pb_q     <= '0;
      new_pb_q     <= '0;
      e_blk_q      <= '0;
      e_resp_q     <= 1'b0;
      tmr_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_err_q   <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            lblk_q   <= req_lblk_i;
            page_q   <= req_page_i;
            wdata_q  <= req_wdata_i;
            old_pb_q <= cur_pb;
            case (req_cmd_i)
              CMD_READ: begin
                resp_valid_q <= 1'b1;
                resp_err_q   <= (rd_state != PG_VALID);
                resp_rdata_q <= (rd_state == PG_VALID) ? rd_data : '0;
              end
              CMD_WRITE: begin
                if (rd_state == PG_ERASED) begin
                  resp_valid_q <= 1'b1;
                  resp_err_q   <= 1'b0;
                  resp_rdata_q <= '0;
                end else if (alloc_found) begin
                  new_pb_q <= alloc_idx;
                  idx_q    <= '0;
                  state_q  <= ST_COPY;
                end else begin
                  resp_valid_q <= 1'b1;
                  resp_err_q   <= 1'b1;
                  resp_rdata_q <= '0;
                end
              end
              CMD_ERASE: begin
                e_blk_q  <= cur_pb;
                e_resp_q <= 1'b1;
                tmr_q    <= '0;
                state_q  <= ST_ERASE;
              end
              default: begin
                resp_valid_q <= 1'b1;
                resp_err_q   <= 1'b1;
                resp_rdata_q <= '0;
              end
            endcase
          end
        end
        ST_COPY: begin
          idx_q <= idx_q + 1'b1;
          if (copy_last) state_q <= ST_SWAP;
        end
        ST_SWAP: begin
          map_q[lblk_q] <= new_pb_q;
          resp_valid_q  <= 1'b1;
          resp_err_q    <= 1'b0;
          resp_rdata_q  <= '0;
          e_blk_q       <= old_pb_q;
          e_resp_q      <= 1'b0;
          tmr_q         <= '0;
          state_q       <= ST_ERASE;
        end
        ST_ERASE: begin
          if (erase_last) begin
            state_q <= ST_IDLE;
            if (e_resp_q) begin
              resp_valid_q <= 1'b1;
              resp_err_q   <= 1'b0;
              resp_rdata_q <= DATA_W'(cnt_next);
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign busy_o       = (state_q == ST_ERASE);
  assign resp_valid_o = resp_valid_q;
  assign resp_err_o   = resp_err_q;
  assign resp_rdata_o = resp_rdata_q;
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int NB        = 6,
  parameter int ERASE_CYC = 50000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [1:0]    req_cmd_i,
  input logic          busy_o,
  input logic [NB-1:0] worn_o
);
  localparam int BC_W = $clog2(ERASE_CYC + 2);
  logic [BC_W-1:0] bc_q;

  // length of the current run of busy cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bc_q <= '0;
    else if (busy_o) bc_q <= (bc_q == BC_W'(ERASE_CYC + 1)) ? bc_q : bc_q + 1'b1;
    else             bc_q <= '0;
  end

  a_r7_busy_blocks_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  a_r7_busy_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bc_q < BC_W'(ERASE_CYC)));

  a_r10_erase_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && bc_q != '0) |-> (bc_q == BC_W'(ERASE_CYC)));

  a_r7_erase_busy_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_cmd_i == 2'd2) |=> busy_o);

  a_r8_worn_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((worn_o & $past(worn_o)) == $past(worn_o)));
endmodule

bind fpm_top fpm_checker #(
  .NB(NUM_PBLK), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_cmd_i   (req_cmd_i),
  .busy_o      (busy_o),
  .worn_o      (worn_o)
);

// File: tb/sim_fpm_top.sv
module sim_fpm_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 2;
  localparam int NB = 3;
  localparam int NP = 32;
  localparam int DW = 16;
  localparam int EC = 4;
  localparam int WM = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_cmd = '0;
  logic [0:0]    req_lblk = '0;
  logic [4:0]    req_page = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, resp_valid, resp_err, busy;
  logic [DW-1:0] resp_rdata;
  logic [NB-1:0] worn;

  int n_checks = 0;
  int n_fail   = 0;

  int            m_map [NL];
  logic [DW-1:0] m_dat [NB][NP];
  int            m_st  [NB][NP];
  int            m_cnt [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_top #(
    .NUM_LBLK(NL), .NUM_PBLK(NB), .PAGES(NP), .DATA_W(DW),
    .ERASE_CYC(EC), .WEAR_MAX(WM)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .req_lblk_i(req_lblk), .req_page_i(req_page),
    .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_err_o(resp_err), .resp_rdata_o(resp_rdata),
    .busy_o(busy), .worn_o(worn)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_alloc();
    for (int b = 0; b < NB; b++) begin
      bit used = 0;
      bit cln = 1;
      for (int l = 0; l < NL; l++) if (m_map[l] == b) used = 1;
      for (int p = 0; p < NP; p++) if (m_st[b][p] != 0) cln = 0;
      if (!used && cln && m_cnt[b] < WM) return b;
    end
    return -1;
  endfunction

  task automatic model_erase(input int b);
    for (int p = 0; p < NP; p++) m_st[b][p] = 0;
    if (m_cnt[b] < WM) m_cnt[b]++;
  endtask

  function automatic int model_worn();
    int w = 0;
    for (int b = 0; b < NB; b++) if (m_cnt[b] >= WM) w |= (1 << b);
    return w;
  endfunction

  task automatic model_op(input int c, input int l, input int p, input logic [DW-1:0] d,
                          output int err, output int rd, output int bexp, output string tag);
    int pb = m_map[l];
    err = 0; rd = 0; bexp = 0; tag = "R9";
    case (c)
      0: begin
        tag = "R2";
        if (m_st[pb][p] == 1) rd = int'(m_dat[pb][p]);
        else err = 1;
      end
      1: begin
        if (m_st[pb][p] == 0) begin
          tag = "R3";
          m_st[pb][p] = 1; m_dat[pb][p] = d;
        end else begin
          int fb = model_alloc();
          if (fb < 0) begin
            tag = "R6"; err = 1;
          end else begin
            tag = "R4";
            for (int q = 0; q < NP; q++) begin
              m_st[fb][q] = m_st[pb][q];
              m_dat[fb][q] = m_dat[pb][q];
            end
            m_st[fb][p] = 1; m_dat[fb][p] = d;
            m_map[l] = fb;
            model_erase(pb);
            bexp = EC;
          end
        end
      end
      2: begin
        tag = "R7";
        model_erase(pb);
        rd = m_cnt[pb];
        bexp = EC;
      end
      default: err = 1;
    endcase
  endtask

  task automatic dut_op(input int c, input int l, input int p, input logic [DW-1:0] d,
                        output int err, output int rd, output int bcyc);
    int t = 0;
    bit got = 0;
    err = -1; rd = -1; bcyc = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'(c); req_lblk = 1'(l); req_page = 5'(p); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (busy) bcyc++;
      if (resp_valid) begin
        got = 1; err = int'(resp_err); rd = int'(resp_rdata);
      end
      if (got && !busy && req_ready) break;
      if (t > 500) begin
        check("R7", "response_timeout", 0, 1);
        break;
      end
      @(negedge clk);
      t++;
    end
  endtask

  task automatic run_op(input int c, input int l, input int p, input logic [DW-1:0] d);
    int e_err, e_rd, e_b, a_err, a_rd, a_b;
    string tag;
    model_op(c, l, p, d, e_err, e_rd, e_b, tag);
    dut_op(c, l, p, d, a_err, a_rd, a_b);
    check(tag, "err", a_err, e_err);
    if (c == 0 || c == 2) check(tag, "rdata", a_rd, e_rd);
    check((c == 1) ? "R10" : "R7", "busy_cycles", a_b, e_b);
    check("R8", "worn", int'(worn), model_worn());
  endtask

  function automatic logic [DW-1:0] pat(input int l, input int p, input int k);
    return DW'(l * 1000 + p * 7 + k * 131 + 1);
  endfunction

  task automatic sweep_reads();
    for (int l = 0; l < NL; l++)
      for (int p = 0; p < NP; p++) run_op(0, l, p, '0);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) m_map[l] = l;
    for (int b = 0; b < NB; b++) begin
      m_cnt[b] = 0;
      for (int p = 0; p < NP; p++) begin m_st[b][p] = 0; m_dat[b][p] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ready", int'(req_ready), 1);
    check("R1", "busy", int'(busy), 0);
    check("R1", "resp_valid", int'(resp_valid), 0);
    check("R1", "worn", int'(worn), 0);

    sweep_reads();                                   // R2 empty pages
    for (int l = 0; l < NL; l++)
      for (int p = 0; p < NP; p++) run_op(1, l, p, pat(l, p, 0));  // R3
    sweep_reads();

    run_op(1, 0, 5, pat(0, 5, 1));                   // R4 relocation
    run_op(1, 1, 0, pat(1, 0, 1));                   // R5 reuse of erased old block
    sweep_reads();

    // R5 R6 R8: spare rotates until the pool runs dry
    for (int k = 0; k < 24; k++) run_op(1, k % 2, (k * 3) % NP, pat(k % 2, k, k + 2));
    sweep_reads();

    for (int k = 0; k < 4; k++) run_op(2, 1, 0, '0); // R7 R8 saturation
    for (int p = 0; p < NP; p++) run_op(0, 1, p, '0);
    run_op(1, 1, 3, 16'h5a5a);                       // R3 after erase
    run_op(0, 1, 3, '0);
    run_op(0, 1, 4, '0);

    run_op(3, 0, 0, 16'h1234);                       // R9 reserved
    for (int p = 0; p < NP; p++) run_op(0, 0, p, '0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule